// File: doc/BRIEF.md
# Character-Cell Text Video Generator

This block turns a character RAM and a font lookup into a 320x240 monochrome pixel stream, which a later stage doubles up to a standard VGA mode. A timing section counts pixels and lines and drives horizontal sync, vertical sync and a video-on flag. From its counters it derives the character column, the text row and the scanline within that row. A fetch section rotates the text row by a scroll offset supplied by the terminal writer, so the picture scrolls without any data moving in RAM. It reads the character code, then reads one 8-bit font row per cell and scanline. The serializer shifts that row out one pixel per clock.

The glyph cell is 8 pixels wide and 10 scanlines high. Every character owns 16 font addresses, of which the first 10 are used. A cursor cell at the writer's position is shown by inverting all of its pixels, and the inversion blinks at a frame-counted rate. The RAM and the font lookup are both synchronous with one clock of read latency. The block issues addresses ahead of time so that each font row is ready on its cell boundary. Every output (sync, video-on, pixel) is delayed by the same amount, which keeps them aligned.

Top module: `text_video_gen`

## Requirements
- R1: While `rst_n` is low, `pixel`, `hsync`, `vsync` and `video_on` are all 0.
- R2: Each frame has exactly ROWS*10 lines with `video_on` high. On each such line `video_on` stays high for exactly COLS*8 consecutive clocks, and successive active lines start H_TOTAL = COLS*8+H_FP+H_SYNC+H_BP clocks apart.
- R3: `hsync` is active high and is never high together with `video_on`. It rises exactly H_FP clocks after `video_on` falls on an active line and stays high for exactly H_SYNC clocks.
- R4: `vsync` is active high, is never high together with `video_on`, and stays high for exactly V_SYNC whole lines (V_SYNC*H_TOTAL clocks).
- R5: The character shown at screen column c and text row r is read from RAM address p*COLS + c, where p = (r + scroll_row) mod ROWS and `scroll_row` < ROWS.
- R6: The font address is {character code (8 bits), scanline (4 bits)}, with the scanline field running 0..9 inside each text row.
- R7: Pixel x of a line shows font bit 7 - (x mod 8), so the most significant bit is drawn first.
- R8: `pixel` is 0 whenever `video_on` is 0.
- R9: While the blink phase is on, every pixel of the cell whose RAM row equals `cursor_row` and whose column equals `cursor_col` is inverted.
- R10: The blink phase is on for the first BLINK_FRAMES frames after reset and then alternates off/on every BLINK_FRAMES frames. While it is off, the cursor cell shows its plain glyph.
- R11: When r + scroll_row reaches ROWS or more, the RAM row wraps to r + scroll_row - ROWS. For example, with scroll_row = ROWS-1, text row 1 reads RAM row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scroll_row | input | RW = clog2(ROWS) | RAM row shown at the top text row |
| cursor_col | input | CW = clog2(COLS) | Cursor column |
| cursor_row | input | RW | Cursor RAM row |
| ram_addr | output | AW = clog2(COLS*ROWS) | Character RAM read address |
| ram_data | input | 8 | Character code, one clock after the address |
| font_addr | output | 12 | Font lookup address {code, scanline} |
| font_data | input | 8 | Font row, one clock after the address |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| video_on | output | 1 | High in the visible region |
| pixel | output | 1 | Monochrome pixel |

## Verification
The hardest situation to reach is the blink-off phase together with a wrapped scroll. It needs several whole frames to go by, and the scroll and cursor inputs must be changed only inside vertical blanking. The bench therefore runs with a small screen (4x3 cells, short porches) and a blink period of two frames. Between frames it reprograms the scroll, the cursor and the RAM contents. It also computes every expected pixel of each frame from modulo arithmetic and a generated font function. Pixel positions are recovered only from `video_on` runs, so any pipeline misalignment shows up as a pixel mismatch.

// File: rtl/tvg_pkg.sv
package tvg_pkg;

  localparam int CELL_W = 8;
  localparam int CELL_H = 10;

  // Per-pixel control carried down the fetch pipeline.
  typedef struct packed {
    logic       act;
    logic       hs;
    logic       vs;
    logic [2:0] px;
    logic [3:0] scan;
    logic       cur;
  } stage_t;

  // True when pos lies in [start, start+len).
  function automatic logic in_window(input int pos, input int start, input int len);
    return (pos >= start) && (pos < start + len);
  endfunction

  // Text row rotated by the scroll offset; off must be below rows.
  function automatic int wrap_row(input int row, input int off, input int rows);
    int s;
    s = row + off;
    return (s >= rows) ? s - rows : s;
  endfunction

  // Linear RAM index of a cell.
  function automatic int cell_index(input int prow, input int col, input int cols);
    return prow * cols + col;
  endfunction

endpackage

// File: rtl/tvg_timing.sv
module tvg_timing #(
  parameter int COLS         = 40,
  parameter int ROWS         = 24,
  parameter int H_FP         = 8,
  parameter int H_SYNC       = 48,
  parameter int H_BP         = 24,
  parameter int V_FP         = 3,
  parameter int V_SYNC       = 4,
  parameter int V_BP         = 15,
  parameter int BLINK_FRAMES = 32,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          active,
  output logic          hs,
  output logic          vs,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [3:0]    scan,
  output logic [2:0]    px,
  output logic          frame_end,
  output logic          blink_on
);
  localparam int H_ACT = COLS * tvg_pkg::CELL_W;
  localparam int V_ACT = ROWS * tvg_pkg::CELL_H;
  localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int FW    = $clog2(BLINK_FRAMES) + 1;

  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic [FW-1:0] fcnt;
  logic          line_end;
  logic          last_active_line;

  assign line_end         = (hc == HW'(H_TOT - 1));
  assign frame_end        = line_end && (vc == VW'(V_TOT - 1));
  assign last_active_line = (vc >= VW'(V_ACT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0;
    end else if (line_end) begin
      hc <= '0;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vc   <= '0;
      row  <= '0;
      scan <= '0;
    end else if (frame_end) begin
      vc   <= '0;
      row  <= '0;
      scan <= '0;
    end else if (line_end) begin
      vc <= vc + 1'b1;
      if (!last_active_line) begin
        if (scan == 4'(tvg_pkg::CELL_H - 1)) begin
          scan <= '0;
          row  <= row + 1'b1;
        end else begin
          scan <= scan + 1'b1;
        end
      end
    end
  end

  assign px     = hc[2:0];
  assign col    = CW'(hc >> 3);
  assign active = (hc < HW'(H_ACT)) && (vc < VW'(V_ACT));
  assign hs     = tvg_pkg::in_window(int'(hc), H_ACT + H_FP, H_SYNC);
  assign vs     = tvg_pkg::in_window(int'(vc), V_ACT + V_FP, V_SYNC);

  // Blink phase: toggles after every BLINK_FRAMES completed frames.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt     <= '0;
      blink_on <= 1'b1;
    end else if (frame_end) begin
      if (fcnt == FW'(BLINK_FRAMES - 1)) begin
        fcnt     <= '0;
        blink_on <= !blink_on;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  // R3
  hs_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> !active);

  // R4
  vs_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vs |-> !active);

  // R2
  hcount_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hc < HW'(H_TOT)) && (vc < VW'(V_TOT)));

  // R10
  blink_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blink_on) |-> $past(frame_end));

endmodule

// File: rtl/tvg_fetch.sv
module tvg_fetch #(
  parameter int COLS = 40,
  parameter int ROWS = 24,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(COLS * ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            hs,
  input  logic            vs,
  input  logic [CW-1:0]   col,
  input  logic [RW-1:0]   row,
  input  logic [3:0]      scan,
  input  logic [2:0]      px,
  input  logic            blink_on,
  input  logic [RW-1:0]   scroll_row,
  input  logic [CW-1:0]   cursor_col,
  input  logic [RW-1:0]   cursor_row,
  output logic [AW-1:0]   ram_addr,
  input  logic [7:0]      ram_data,
  output logic [11:0]     font_addr,
  output tvg_pkg::stage_t st2
);
  tvg_pkg::stage_t st0, st1;
  logic [RW-1:0]   prow;
  logic            cursor_hit;

  // Stage 0: RAM address from the rotated row.
  assign prow       = RW'(tvg_pkg::wrap_row(int'(row), int'(scroll_row), ROWS));
  assign ram_addr   = AW'(tvg_pkg::cell_index(int'(prow), int'(col), COLS));
  assign cursor_hit = blink_on && (prow == cursor_row) && (col == cursor_col);

  always_comb begin
    st0.act  = active;
    st0.hs   = hs;
    st0.vs   = vs;
    st0.px   = px;
    st0.scan = scan;
    st0.cur  = cursor_hit;
  end

  // Stage 1: character code is back, form the font address.
  // Stage 2: font row is back.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1 <= st0;
      st2 <= st1;
    end
  end

  assign font_addr = {ram_data, st1.scan};

  // R5
  ram_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (ram_addr < AW'(COLS * ROWS)));

  // R6
  scan_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st1.act |-> (font_addr[3:0] < 4'(tvg_pkg::CELL_H)));

endmodule

// File: rtl/tvg_serializer.sv
module tvg_serializer (
  input  logic            clk,
  input  logic            rst_n,
  input  tvg_pkg::stage_t st,
  input  logic [7:0]      font_data,
  output logic            pixel,
  output logic            hsync,
  output logic            vsync,
  output logic            video_on
);
  logic [7:0] shreg;
  logic       cell_start;
  logic       bit_now;

  assign cell_start = (st.px == 3'd0);
  assign bit_now    = cell_start ? font_data[7] : shreg[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (cell_start) begin
      shreg <= {font_data[6:0], 1'b0};
    end else begin
      shreg <= {shreg[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pixel    <= 1'b0;
      hsync    <= 1'b0;
      vsync    <= 1'b0;
      video_on <= 1'b0;
    end else begin
      pixel    <= st.act && (bit_now ^ st.cur);
      hsync    <= st.hs;
      vsync    <= st.vs;
      video_on <= st.act;
    end
  end

  // R8
  blank_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !video_on |-> !pixel);

  // R3
  hsync_video_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hsync && video_on));

endmodule

// File: rtl/text_video_gen.sv
module text_video_gen #(
  parameter int COLS         = 40,
  parameter int ROWS         = 24,
  parameter int H_FP         = 8,
  parameter int H_SYNC       = 48,
  parameter int H_BP         = 24,
  parameter int V_FP         = 3,
  parameter int V_SYNC       = 4,
  parameter int V_BP         = 15,
  parameter int BLINK_FRAMES = 32,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] scroll_row,
  input  logic [CW-1:0] cursor_col,
  input  logic [RW-1:0] cursor_row,
  output logic [AW-1:0] ram_addr,
  input  logic [7:0]    ram_data,
  output logic [11:0]   font_addr,
  input  logic [7:0]    font_data,
  output logic          hsync,
  output logic          vsync,
  output logic          video_on,
  output logic          pixel
);
  logic            t_active, t_hs, t_vs, t_frame_end, t_blink;
  logic [CW-1:0]   t_col;
  logic [RW-1:0]   t_row;
  logic [3:0]      t_scan;
  logic [2:0]      t_px;
  tvg_pkg::stage_t f_st2;

  tvg_timing #(
    .COLS(COLS), .ROWS(ROWS),
    .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .BLINK_FRAMES(BLINK_FRAMES)
  ) u_timing (
    .clk(clk), .rst_n(rst_n),
    .active(t_active), .hs(t_hs), .vs(t_vs),
    .col(t_col), .row(t_row), .scan(t_scan), .px(t_px),
    .frame_end(t_frame_end), .blink_on(t_blink)
  );

  tvg_fetch #(.COLS(COLS), .ROWS(ROWS)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .active(t_active), .hs(t_hs), .vs(t_vs),
    .col(t_col), .row(t_row), .scan(t_scan), .px(t_px),
    .blink_on(t_blink),
    .scroll_row(scroll_row), .cursor_col(cursor_col), .cursor_row(cursor_row),
    .ram_addr(ram_addr), .ram_data(ram_data),
    .font_addr(font_addr), .st2(f_st2)
  );

  tvg_serializer u_ser (
    .clk(clk), .rst_n(rst_n),
    .st(f_st2), .font_data(font_data),
    .pixel(pixel), .hsync(hsync), .vsync(vsync), .video_on(video_on)
  );

endmodule

// File: tb/sim_text_video_gen.sv
module sim_text_video_gen;
  localparam int COLS = 4, ROWS = 3;
  localparam int H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_FP = 1, V_SYNC = 2, V_BP = 2;
  localparam int BLINK = 2;
  localparam int W = COLS * 8, H = ROWS * 10;
  localparam int HT = W + H_FP + H_SYNC + H_BP;
  localparam int NCELL = COLS * ROWS;
  localparam int NF = 8;

  typedef struct { bit v; string tag; } exp_t;

  logic clk = 0, rst_n = 0;
  logic [1:0] scroll_row = 0, cursor_col = 0, cursor_row = 0;
  logic [3:0] ram_addr;
  logic [7:0] ram_q = 0, font_q = 0;
  logic [11:0] font_addr;
  logic hsync, vsync, video_on, pixel;

  bit [7:0] mem [0:NCELL-1];
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  text_video_gen #(.COLS(COLS), .ROWS(ROWS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .BLINK_FRAMES(BLINK)) u0 (
    .clk(clk), .rst_n(rst_n), .scroll_row(scroll_row), .cursor_col(cursor_col),
    .cursor_row(cursor_row), .ram_addr(ram_addr), .ram_data(ram_q),
    .font_addr(font_addr), .font_data(font_q),
    .hsync(hsync), .vsync(vsync), .video_on(video_on), .pixel(pixel));

  function automatic logic [7:0] font_fn(input logic [11:0] a);
    return (a[7:0] * 8'd37) ^ {a[3:0], a[11:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    ram_q  <= (int'(ram_addr) < NCELL) ? mem[ram_addr] : 8'h00;
    font_q <= font_fn(font_addr);
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // Driver: pushes the expected pixels of one frame.
  task automatic push_frame(input int f, input int sc, input int cc, input int cr);
    bit on;
    on = ((f / BLINK) % 2) == 0;                         // R10 phase
    for (int y = 0; y < H; y++) begin
      for (int x = 0; x < W; x++) begin
        exp_t e;
        int c, r, s, p;
        logic [7:0] fb;
        bit cur;
        c = x / 8; r = y / 10; s = y % 10;
        p = (r + sc) % ROWS;                             // R5 / R11
        fb = font_fn({mem[p * COLS + c], 4'(s)});        // R6
        cur = (p == cr) && (c == cc);
        e.v = fb[7 - (x % 8)] ^ (cur && on);             // R7, R9
        if (cur) e.tag = on ? "R9" : "R10";
        else if (r + sc >= ROWS) e.tag = "R11";
        else if (x % 8 == 0) e.tag = "R7";
        else if (s % 2 == 1) e.tag = "R6";
        else e.tag = "R5";
        exp_q.push_back(e);
      end
    end
  endtask

  // Monitor
  int on_run = 0, hs_run = 0, vs_run = 0, low_cnt = 0, since_rise = 0, lines = 0;
  bit p_on = 0, p_hs = 0, p_vs = 0, had = 0, seen_rise = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (video_on) begin
        if (exp_q.size() == 0) chk(0, "R2", int'(pixel), -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(pixel == e.v, e.tag, int'(pixel), int'(e.v));
        end
      end else chk(pixel == 1'b0, "R8", int'(pixel), 0);
      if (hsync && video_on) chk(0, "R3", 1, 0);
      if (vsync && video_on) chk(0, "R4", 1, 0);

      if (video_on) on_run++;
      else if (p_on) begin chk(on_run == W, "R2", on_run, W); on_run = 0; end
      if (video_on && !p_on) begin
        if (seen_rise) chk(since_rise == HT, "R2", since_rise, HT);
        seen_rise = 1; since_rise = 0; lines++;
      end
      since_rise++;

      if (video_on) begin low_cnt = 0; had = 1; end
      else if (!hsync) low_cnt++;
      if (hsync && !p_hs && had) chk(low_cnt == H_FP, "R3", low_cnt, H_FP);
      if (hsync) hs_run++;
      else if (p_hs) begin chk(hs_run == H_SYNC, "R3", hs_run, H_SYNC); hs_run = 0; had = 0; end

      if (vsync && !p_vs) begin chk(lines == H, "R2", lines, H); lines = 0; seen_rise = 0; end
      if (vsync) vs_run++;
      else if (p_vs) begin chk(vs_run == V_SYNC * HT, "R4", vs_run, V_SYNC * HT); vs_run = 0; end

      p_on = video_on; p_hs = hsync; p_vs = vsync;
    end
  end

  task automatic wait_vsync_end();
    do @(negedge clk); while (!vsync);
    do @(negedge clk); while (vsync);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    int sc_t[NF] = '{0, 1, 2, 2, 0, 1, 2, 0};
    int cc_t[NF] = '{0, 3, 1, 3, 2, 0, 3, 1};
    int cr_t[NF] = '{0, 2, 1, 0, 2, 1, 2, 0};
    for (int i = 0; i < NCELL; i++) mem[i] = 8'(i * 13 + 5);
    repeat (3) @(negedge clk);
    // R1: outputs held low in reset
    chk(pixel == 0, "R1", int'(pixel), 0);
    chk(hsync == 0, "R1", int'(hsync), 0);
    chk(vsync == 0, "R1", int'(vsync), 0);
    chk(video_on == 0, "R1", int'(video_on), 0);
    for (int f = 0; f < NF; f++) begin
      if (f == 4) for (int i = 0; i < NCELL; i++) mem[i] = 8'(i * 7 + 3 + f);
      scroll_row = 2'(sc_t[f]); cursor_col = 2'(cc_t[f]); cursor_row = 2'(cr_t[f]);
      push_frame(f, sc_t[f], cc_t[f], cr_t[f]);
      if (f == 0) begin @(negedge clk); rst_n = 1; end
      wait_vsync_end();
      chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
      exp_q.delete();
    end
    done = 1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

endmodule